// File: doc/BRIEF.md
# Split-Word Float Comparator

This block compares two IEEE single-precision values and returns the truth of a selected relation as a 16-bit word holding 0 or 1. Each operand reaches the block as two 16-bit halves, a low half and a high half, as they would be read from two neighbouring memory words. The block joins the halves into a 32-bit value, sorts out the special encodings (signed zeros, infinities, NaNs, denormals) and orders the two operands by sign-magnitude rules.

A 3-bit relation code picks one of six relations. The answer is registered. It appears one clock after a request marked valid, together with a result-valid strobe. Between requests the result word keeps its last value. The ordering core can be built in either of two equivalent forms, chosen by a parameter.

Top module: `split_float_cmp`

## Requirements
- R1: Each operand is the 32-bit word {high half, low half}. Bit 31 is the sign, bits 30:23 are the biased exponent and bits 22:0 are the fraction. Low-half bits take part in the comparison.
- R2: The relation codes are 0 equal, 1 not equal, 2 less, 3 less-or-equal, 4 greater and 5 greater-or-equal, with A on the left. Bit 0 of the result word is 1 for true and 0 for false, and bits 15:1 are always 0.
- R3: When `in_valid` is high at a clock edge, `res_valid` is high after that edge and `res_word` carries the answer for the inputs sampled at that edge. When `in_valid` is low at an edge, `res_valid` is low after it.
- R4: An edge with `in_valid` low leaves `res_word` unchanged, whatever the other inputs are.
- R5: +0 (0x00000000) and -0 (0x80000000) compare as equal.
- R6: If either operand is a NaN (exponent all ones, fraction nonzero), the not-equal relation yields 1 and every other relation yields 0.
- R7: Positive values order by magnitude. The smallest denormal (0x00000001) is above +0, the largest finite value (0x7F7FFFFF) is below +infinity (0x7F800000), and every negative value is below every positive value.
- R8: Negative values order by inverted magnitude. -infinity (0xFF800000) is below -max (0xFF7FFFFF), and the negative denormal nearest zero (0x80000001) is below -0.
- R9: Relation codes 6 and 7 yield 0.
- R10: While `rst_n` is low, `res_valid` and `res_word` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| a_lo | input | 16 | Operand A, low half |
| a_hi | input | 16 | Operand A, high half |
| b_lo | input | 16 | Operand B, low half |
| b_hi | input | 16 | Operand B, high half |
| pred | input | 3 | Relation code |
| res_valid | output | 1 | Result strobe, one cycle after request |
| res_word | output | 16 | Answer as 0 or 1 |

## Verification
The hardest cases to reach are the pairs where sign and magnitude disagree. These are the two zeros, negative values whose order is inverted, NaN against infinity, and pairs that differ only in their low half. Random operands almost never produce them. The stimulus is therefore a fixed set of fourteen boundary encodings, crossed pairwise under all eight relation codes. An idle cycle with scrambled inputs follows every pair, so the hold behaviour and the strobe drop are seen many times. A behavioural model decodes each operand to a real number, with NaN kept as a flag, and predicts the output every cycle.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

   typedef enum logic [2:0] {
      REL_EQ = 3'd0,
      REL_NE = 3'd1,
      REL_LT = 3'd2,
      REL_LE = 3'd3,
      REL_GT = 3'd4,
      REL_GE = 3'd5
   } rel_code_e;

   typedef struct packed {
      logic lt;
      logic eq;
      logic gt;
   } order_t;

   localparam int ORDER_SIGN_MAG = 0;
   localparam int ORDER_KEYED    = 1;

endpackage

// File: rtl/sfc_unpack.sv
module sfc_unpack #(
   parameter int WORD_W = 16,
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int FULL_W = 2 * WORD_W,
   localparam int MAG_W  = EXP_W + FRAC_W
) (
   input  logic [WORD_W-1:0] lo_half,
   input  logic [WORD_W-1:0] hi_half,
   output logic              sign,
   output logic [MAG_W-1:0]  mag,
   output logic              is_nan,
   output logic              is_zero
);

   generate
      if (FULL_W != 1 + MAG_W) begin : g_bad_split
         $error("sfc_unpack: two halves must hold sign, exponent and fraction exactly");
      end
   endgenerate

   logic [FULL_W-1:0] whole;
   logic [EXP_W-1:0]  expo;
   logic [FRAC_W-1:0] frac;

   always_comb begin
      whole   = {hi_half, lo_half};
      sign    = whole[FULL_W-1];
      mag     = whole[MAG_W-1:0];
      expo    = whole[MAG_W-1 -: EXP_W];
      frac    = whole[FRAC_W-1:0];
      is_nan  = (&expo) && (|frac);
      is_zero = ~|mag;
   end

endmodule

// File: rtl/sfc_order.sv
module sfc_order
   import sfc_pkg::*;
#(
   parameter int MAG_W       = 31,
   parameter int ORDER_STYLE = ORDER_SIGN_MAG
) (
   input  logic             sign_a,
   input  logic [MAG_W-1:0] mag_a,
   input  logic             sign_b,
   input  logic [MAG_W-1:0] mag_b,
   input  logic             nan_any,
   input  logic             zero_both,
   output order_t           rel
);

   generate
      if (ORDER_STYLE != ORDER_SIGN_MAG && ORDER_STYLE != ORDER_KEYED) begin : g_bad_style
         $error("sfc_order: unknown ORDER_STYLE");
      end

      if (ORDER_STYLE == ORDER_SIGN_MAG) begin : g_signmag
         always_comb begin
            rel = '0;
            if (nan_any) begin
               rel = '0;
            end else if (zero_both) begin
               rel.eq = 1'b1;
            end else if (sign_a != sign_b) begin
               rel.lt = sign_a;
               rel.gt = sign_b;
            end else if (mag_a == mag_b) begin
               rel.eq = 1'b1;
            end else if (sign_a) begin
               rel.lt = (mag_a > mag_b);
               rel.gt = (mag_a < mag_b);
            end else begin
               rel.lt = (mag_a < mag_b);
               rel.gt = (mag_a > mag_b);
            end
         end
      end else begin : g_keyed
         logic [MAG_W:0] key_a;
         logic [MAG_W:0] key_b;
         always_comb begin
            key_a = sign_a ? ~{1'b1, mag_a} : {1'b1, mag_a};
            key_b = sign_b ? ~{1'b1, mag_b} : {1'b1, mag_b};
            rel   = '0;
            if (nan_any) begin
               rel = '0;
            end else if (zero_both || key_a == key_b) begin
               rel.eq = 1'b1;
            end else begin
               rel.lt = (key_a < key_b);
               rel.gt = (key_a > key_b);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/sfc_select.sv
module sfc_select
   import sfc_pkg::*;
(
   input  logic [2:0] code,
   input  order_t     rel,
   output logic       truth
);

   always_comb begin
      case (code)
         REL_EQ:  truth = rel.eq;
         REL_NE:  truth = ~rel.eq;
         REL_LT:  truth = rel.lt;
         REL_LE:  truth = rel.lt | rel.eq;
         REL_GT:  truth = rel.gt;
         REL_GE:  truth = rel.gt | rel.eq;
         default: truth = 1'b0;
      endcase
   end

endmodule

// File: rtl/split_float_cmp.sv
module split_float_cmp
   import sfc_pkg::*;
#(
   parameter int WORD_W      = 16,
   parameter int EXP_W       = 8,
   parameter int FRAC_W      = 23,
   parameter int ORDER_STYLE = ORDER_SIGN_MAG,
   localparam int MAG_W      = EXP_W + FRAC_W,
   localparam int N_OPS      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] a_lo,
   input  logic [WORD_W-1:0] a_hi,
   input  logic [WORD_W-1:0] b_lo,
   input  logic [WORD_W-1:0] b_hi,
   input  logic [2:0]        pred,
   output logic              res_valid,
   output logic [WORD_W-1:0] res_word
);

   generate
      if (WORD_W < 2) begin : g_bad_word
         $error("split_float_cmp: WORD_W too small for result word");
      end
   endgenerate

   logic [WORD_W-1:0] lo_in   [N_OPS];
   logic [WORD_W-1:0] hi_in   [N_OPS];
   logic              op_sign [N_OPS];
   logic [MAG_W-1:0]  op_mag  [N_OPS];
   logic              op_nan  [N_OPS];
   logic              op_zero [N_OPS];

   assign lo_in[0] = a_lo;
   assign hi_in[0] = a_hi;
   assign lo_in[1] = b_lo;
   assign hi_in[1] = b_hi;

   for (genvar g = 0; g < N_OPS; g++) begin : g_op
      sfc_unpack #(
         .WORD_W (WORD_W),
         .EXP_W  (EXP_W),
         .FRAC_W (FRAC_W)
      ) u_unpack (
         .lo_half (lo_in[g]),
         .hi_half (hi_in[g]),
         .sign    (op_sign[g]),
         .mag     (op_mag[g]),
         .is_nan  (op_nan[g]),
         .is_zero (op_zero[g])
      );
   end

   logic   nan_any;
   logic   zero_both;
   order_t rel;
   logic   truth;

   assign nan_any   = op_nan[0] | op_nan[1];
   assign zero_both = op_zero[0] & op_zero[1];

   sfc_order #(
      .MAG_W       (MAG_W),
      .ORDER_STYLE (ORDER_STYLE)
   ) u_order (
      .sign_a    (op_sign[0]),
      .mag_a     (op_mag[0]),
      .sign_b    (op_sign[1]),
      .mag_b     (op_mag[1]),
      .nan_any   (nan_any),
      .zero_both (zero_both),
      .rel       (rel)
   );

   sfc_select u_select (
      .code  (pred),
      .rel   (rel),
      .truth (truth)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_word  <= '0;
      end else begin
         res_valid <= in_valid;
         if (in_valid) begin
            res_word <= {{(WORD_W-1){1'b0}}, truth};
         end
      end
   end

   // R3: strobe follows the request by one edge
   assert_valid_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> res_valid);
   assert_valid_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !res_valid);

   // R4: idle edges keep the answer
   assert_hold_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(res_word));

   // R2: only bit 0 may be set
   assert_bool_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
      res_word[WORD_W-1:1] == '0);

   // R7: ordering core yields at most one relation
   assert_order_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rel));

   // R6: unordered operands produce no relation; not-equal answers 1
   assert_nan_unordered_R6: assert property (@(posedge clk) disable iff (!rst_n)
      nan_any |-> (rel == '0));
   assert_nan_ne_true_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && nan_any && pred == REL_NE) |=> (res_word == 1));

   // R5: zeros of either sign are equal
   assert_zero_equal_R5: assert property (@(posedge clk) disable iff (!rst_n)
      zero_both |-> rel.eq);

   // R9: unused codes answer 0
   assert_unused_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && pred > 3'd5) |=> (res_word == '0));

endmodule

// File: tb/sim_split_float_cmp.sv
`timescale 1ns/1ps
module sim_split_float_cmp;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [15:0] a_lo = '0, a_hi = '0, b_lo = '0, b_hi = '0;
   logic [2:0]  pred = '0;
   logic        res_valid;
   logic [15:0] res_word;

   int          n_checks = 0;
   int          n_fail = 0;
   int          cycles = 0;
   bit          done = 1'b0;
   logic        exp_v = 1'b0;
   logic [15:0] exp_w = '0;

   split_float_cmp u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .a_lo      (a_lo),
      .a_hi      (a_hi),
      .b_lo      (b_lo),
      .b_hi      (b_hi),
      .pred      (pred),
      .res_valid (res_valid),
      .res_word  (res_word)
   );

   always #2.5 clk = ~clk;
   always @(posedge clk) cycles++;

   function automatic bit is_nan(logic [31:0] w);
      return (w[30:23] == 8'hFF) && (w[22:0] != 0);
   endfunction

   function automatic real to_real(logic [31:0] w);
      real v;
      int  e;
      e = int'(w[30:23]);
      if (e == 255)    v = 1.0e300;
      else if (e == 0) v = real'(w[22:0]) * (2.0 ** (-149.0));
      else             v = real'(w[22:0] + 32'd8388608) * (2.0 ** real'(e - 150));
      return w[31] ? -v : v;
   endfunction

   function automatic logic [15:0] model(logic [31:0] a, logic [31:0] b, logic [2:0] p);
      real x, y;
      bit  t;
      if (p > 3'd5) return 16'd0;
      if (is_nan(a) || is_nan(b)) return (p == 3'd1) ? 16'd1 : 16'd0;
      x = to_real(a);
      y = to_real(b);
      case (p)
         3'd0: t = (x == y);
         3'd1: t = (x != y);
         3'd2: t = (x < y);
         3'd3: t = (x <= y);
         3'd4: t = (x > y);
         default: t = (x >= y);
      endcase
      return {15'd0, t};
   endfunction

   function automatic string req_tag(logic [31:0] a, logic [31:0] b, logic [2:0] p);
      if (p > 3'd5) return "R9";
      if (is_nan(a) || is_nan(b)) return "R6";
      if (a[30:0] == 0 && b[30:0] == 0) return "R5";
      if (a == b) return "R2";
      if (a[31:16] == b[31:16]) return "R1";
      if (a[31] && b[31]) return "R8";
      return "R7";
   endfunction

   task automatic check(string tag);
      n_checks++;
      if (res_valid !== exp_v || res_word !== exp_w) begin
         n_fail++;
         $display("FAIL %s: got valid=%b word=%h, expected valid=%b word=%h",
                  tag, res_valid, res_word, exp_v, exp_w);
      end
   endtask

   task automatic step(bit v, logic [31:0] a, logic [31:0] b, logic [2:0] p, string tag);
      in_valid = v;
      a_lo = a[15:0];
      a_hi = a[31:16];
      b_lo = b[15:0];
      b_hi = b[31:16];
      pred = p;
      @(posedge clk);
      if (v) exp_w = model(a, b, p);
      exp_v = v;
      @(negedge clk);
      check(tag);
   endtask

   task automatic report();
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   logic [31:0] vals [14] = '{
      32'h0000_0000, 32'h8000_0000, 32'h3F80_0000, 32'hBF80_0000,
      32'h4000_0000, 32'h0000_0001, 32'h8000_0001, 32'h7F7F_FFFF,
      32'hFF7F_FFFF, 32'h7F80_0000, 32'hFF80_0000, 32'h7FC0_0000,
      32'h3FC0_0000, 32'h3F80_0001
   };

   initial begin
      wait (cycles > 150000 || done);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL R3: watchdog expired, got no completion, expected completion");
         report();
      end
   end

   initial begin
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      exp_v = 1'b0;
      exp_w = '0;
      check("R10");
      rst_n = 1'b1;
      @(negedge clk);
      check("R10");
      for (int i = 0; i < 14; i++) begin
         for (int j = 0; j < 14; j++) begin
            for (int p = 0; p < 8; p++) begin
               step(1'b1, vals[i], vals[j], 3'(p), req_tag(vals[i], vals[j], 3'(p)));
            end
            step(1'b0, vals[j] ^ 32'h5A5A_A5A5, vals[i], 3'(i + j), "R3/R4");
         end
      end
      done = 1'b1;
      report();
   end

endmodule